// File: doc/BRIEF.md
# MAC Control and Interrupt Register Bank

This block holds the 32-bit control and status registers of a network MAC. A processor reaches it through a simple synchronous bus: a word address, write data, a write enable, and a registered read data port. Each register has its own mask of read-only bits and its own mask of write-one-to-clear bits. A write merges the stored value with the bus data through these masks. Read-only bits keep their stored value. Write-one-to-clear bits keep their value unless they are written with one, in which case they clear. All other bits take the new data.

An interrupt section holds a status word, a mask word, and two write-only command words. One command word unmasks the bits written to it and the other masks them. Event pulses from the rest of the MAC raise status bits, but only where the mask bit is clear. A level interrupt output is high while any status bit is set and unmasked. A one-hot write strobe marks the register being written, so that neighbouring blocks can start the side effects they own.

Word addresses: 0 control, 1 configuration, 2 status, 3 interrupt status, 4 interrupt unmask command, 5 interrupt mask command, 6 interrupt mask, 7 auxiliary.

Top module: `reg_bank`

## Requirements
- R1: In the control register (address 0), bits 31 to 19 ignore writes and bits 18 to 0 take the written value. The configuration register (address 1) takes all 32 written bits.
- R2: The status register (address 2) ignores every write and always reads 0x00000006.
- R3: In the auxiliary register (address 7), bits 31 to 24 are read-only. Bits 23 to 16 clear where written with 1 and hold where written with 0. Bits 15 to 0 take the written value. Its reset value is 0x5A3C0000.
- R4: After the bus presents an address for one clock, bus_rdata shows the value the register held before that clock edge. Addresses 4 and 5 always read zero.
- R5: An event pulse bit sets the matching interrupt status bit (address 3) only while the matching mask bit is clear. If an event and a clearing write hit the same bit in the same clock, the bit ends up set.
- R6: Every bit of the interrupt status register clears where written with 1 and holds where written with 0.
- R7: A write to address 5 sets every interrupt mask bit (address 6) that is one in the data, and leaves the other mask bits unchanged.
- R8: A write to address 4 clears every mask bit that is one in the data. A direct write to address 6 has no effect.
- R9: irq_o is high exactly when some interrupt status bit is set and its mask bit is clear. It follows the stored state with no added delay.
- R10: Reset clears the interrupt status, sets all mask bits, clears control and configuration, and drives irq_o low.
- R11: While bus_we is high, wr_stb_o has exactly the bit of the addressed register set. While bus_we is low, wr_stb_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_i | input | 32 | Event pulses that raise interrupt status bits |
| wr_stb_o | output | 8 | One-hot write strobe, one bit per register |
| irq_o | output | 1 | Level interrupt request |

## Verification
The properties rely on one thing about the inputs: the bus carries at most one write per clock, so a single address cannot both unmask and mask in the same edge. Event pulses may arrive at any time, including during a write. The properties check masking and clearing bit by bit relative to the previous mask and the previous write data, and they hold for any mix of these inputs. The stimulus writes and reads only one address per clock. It drives events both alone and in the same clock as a clearing write to the same status bit, which covers the collision rule.

// File: rtl/reg_bank_pkg.sv
package reg_bank_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        RB_CTRL      = 3'd0,
        RB_CFG       = 3'd1,
        RB_STAT      = 3'd2,
        RB_IRQ_STAT  = 3'd3,
        RB_IRQ_EN    = 3'd4,
        RB_IRQ_DIS   = 3'd5,
        RB_IRQ_MASK  = 3'd6,
        RB_AUX       = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
    } bus_req_t;

    typedef struct packed {
        word_t ro;
        word_t w1c;
        word_t rst;
    } reg_attr_t;

    localparam word_t STAT_RST_VAL = 32'h0000_0006;

    // Attributes of the registers that live in the generic storage array.
    function automatic reg_attr_t reg_attr(input int unsigned idx);
        reg_attr_t a;
        a = '{ro: '0, w1c: '0, rst: '0};
        case (idx)
            int'(RB_CTRL): a.ro  = 32'hFFF8_0000;
            int'(RB_STAT): begin
                a.ro  = '1;
                a.rst = STAT_RST_VAL;
            end
            int'(RB_AUX): begin
                a.ro  = 32'hFF00_0000;
                a.w1c = 32'h00FF_0000;
                a.rst = 32'h5A3C_0000;
            end
            default: a = '{ro: '0, w1c: '0, rst: '0};
        endcase
        return a;
    endfunction

    // True for registers held in the generic storage array.
    function automatic logic is_plain(input int unsigned idx);
        return (idx == int'(RB_CTRL)) || (idx == int'(RB_CFG)) ||
               (idx == int'(RB_STAT)) || (idx == int'(RB_AUX));
    endfunction

endpackage

// File: rtl/reg_bank_wmerge.sv
module reg_bank_wmerge #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] ro_mask_i,
    input  logic [W-1:0] w1c_mask_i,
    input  logic         wr_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] keep_ro;
    logic [W-1:0] keep_w1c;
    logic [W-1:0] fresh;

    always_comb begin
        // Read-only bits take precedence over the clear-on-one bits.
        keep_ro  = cur_i & ro_mask_i;
        keep_w1c = cur_i & w1c_mask_i & ~ro_mask_i & ~wdata_i;
        fresh    = wdata_i & ~ro_mask_i & ~w1c_mask_i;
        nxt_o    = wr_i ? (keep_ro | keep_w1c | fresh) : cur_i;
    end
endmodule

// File: rtl/reg_bank_irq.sv
module reg_bank_irq
    import reg_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stat_i,
    input  logic  wr_en_i,
    input  logic  wr_dis_i,
    input  word_t wdata_i,
    input  word_t evt_i,
    output word_t stat_o,
    output word_t mask_o,
    output logic  irq_o
);
    word_t stat_q;
    word_t mask_q;
    word_t stat_merged;
    word_t stat_d;
    word_t mask_d;

    reg_bank_wmerge #(.W(DATA_W)) u_stat_merge (
        .cur_i      (stat_q),
        .wdata_i    (wdata_i),
        .ro_mask_i  ('0),
        .w1c_mask_i ('1),
        .wr_i       (wr_stat_i),
        .nxt_o      (stat_merged)
    );

    always_comb begin
        // An unmasked event wins over a clearing write in the same cycle.
        stat_d = stat_merged | (evt_i & ~mask_q);
        mask_d = mask_q;
        if (wr_dis_i) begin
            mask_d = mask_q | wdata_i;
        end else if (wr_en_i) begin
            mask_d = mask_q & ~wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= stat_d;
            mask_q <= mask_d;
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign irq_o  = |(stat_q & ~mask_q);
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import reg_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [DATA_W-1:0]   evt_i,
    output logic [NUM_REGS-1:0] wr_stb_o,
    output logic                irq_o
);
    bus_req_t req;
    word_t    reg_view [NUM_REGS];
    word_t    irq_stat;
    word_t    irq_mask;

    assign req = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    always_comb begin
        wr_stb_o = '0;
        if (req.we) begin
            wr_stb_o[req.addr] = 1'b1;
        end
    end

    reg_bank_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .wr_stat_i (wr_stb_o[RB_IRQ_STAT]),
        .wr_en_i   (wr_stb_o[RB_IRQ_EN]),
        .wr_dis_i  (wr_stb_o[RB_IRQ_DIS]),
        .wdata_i   (req.wdata),
        .evt_i     (evt_i),
        .stat_o    (irq_stat),
        .mask_o    (irq_mask),
        .irq_o     (irq_o)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (is_plain(g)) begin : g_store
            localparam reg_attr_t ATTR = reg_attr(g);
            word_t q;
            word_t d;

            reg_bank_wmerge #(.W(DATA_W)) u_merge (
                .cur_i      (q),
                .wdata_i    (req.wdata),
                .ro_mask_i  (ATTR.ro),
                .w1c_mask_i (ATTR.w1c),
                .wr_i       (wr_stb_o[g]),
                .nxt_o      (d)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= ATTR.rst;
                end else begin
                    q <= d;
                end
            end
            assign reg_view[g] = q;
        end else if (g == int'(RB_IRQ_STAT)) begin : g_stat
            assign reg_view[g] = irq_stat;
        end else if (g == int'(RB_IRQ_MASK)) begin : g_mask
            assign reg_view[g] = irq_mask;
        end else begin : g_cmd
            assign reg_view[g] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= reg_view[req.addr];
        end
    end
endmodule

// File: rtl/reg_bank_chk.sv
module reg_bank_chk
    import reg_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] evt_i,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] isr_q,
    input logic [DATA_W-1:0] imr_q,
    input logic              irq_o
);
    assert_ctrl_ro_R1: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[31:19] == $past(ctrl_q[31:19]));

    assert_stat_const_R2: assert property (@(posedge clk) disable iff (rst)
        stat_q == 32'h0000_0006);

    assert_masked_evt_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((isr_q & ~$past(isr_q) & $past(imr_q)) == '0));

    assert_isr_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd3 && evt_i == '0) |=>
        ((isr_q & $past(bus_wdata)) == '0));

    assert_dis_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd5) |=>
        ((imr_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_en_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd4) |=> ((imr_q & $past(bus_wdata)) == '0));

    assert_all_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (imr_q == '1) |-> !irq_o);
endmodule

bind reg_bank reg_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_i     (evt_i),
    .ctrl_q    (reg_view[0]),
    .stat_q    (reg_view[2]),
    .isr_q     (reg_view[3]),
    .imr_q     (reg_view[6]),
    .irq_o     (irq_o)
);

// File: tb/reg_bank_bench.sv
module reg_bank_bench;
    import reg_bank_pkg::*;

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    // wr=1: write data; wr=0: read and compare against exp.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 32'h0, 32'h0000_0000, 4'd10},  // R10 ctrl reset
        '{1'b0, 3'd1, 32'h0, 32'h0000_0000, 4'd10},  // R10 cfg reset
        '{1'b0, 3'd2, 32'h0, 32'h0000_0006, 4'd2},   // R2 status value
        '{1'b0, 3'd6, 32'h0, 32'hFFFF_FFFF, 4'd10},  // R10 mask all set
        '{1'b0, 3'd3, 32'h0, 32'h0000_0000, 4'd10},  // R10 status clear
        '{1'b0, 3'd7, 32'h0, 32'h5A3C_0000, 4'd3},   // R3 aux reset
        '{1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0, 4'd1},
        '{1'b0, 3'd0, 32'h0, 32'h0007_FFFF, 4'd1},   // R1 upper bits held
        '{1'b1, 3'd1, 32'h1234_5678, 32'h0, 4'd1},
        '{1'b0, 3'd1, 32'h0, 32'h1234_5678, 4'd1},   // R1 cfg plain
        '{1'b1, 3'd2, 32'h0000_0000, 32'h0, 4'd2},
        '{1'b0, 3'd2, 32'h0, 32'h0000_0006, 4'd2},   // R2 write ignored
        '{1'b1, 3'd7, 32'h0005_ABCD, 32'h0, 4'd3},
        '{1'b0, 3'd7, 32'h0, 32'h5A38_ABCD, 4'd3},   // R3 partial clear
        '{1'b1, 3'd7, 32'hFFFF_0000, 32'h0, 4'd3},
        '{1'b0, 3'd7, 32'h0, 32'h5A00_0000, 4'd3},   // R3 full clear
        '{1'b1, 3'd6, 32'h0000_0000, 32'h0, 4'd8},
        '{1'b0, 3'd6, 32'h0, 32'hFFFF_FFFF, 4'd8},   // R8 direct write ignored
        '{1'b1, 3'd4, 32'h0000_00F0, 32'h0, 4'd8},
        '{1'b0, 3'd6, 32'h0, 32'hFFFF_FF0F, 4'd8},   // R8 unmask
        '{1'b0, 3'd4, 32'h0, 32'h0000_0000, 4'd4},   // R4 command reads zero
        '{1'b0, 3'd5, 32'h0, 32'h0000_0000, 4'd4},   // R4 command reads zero
        '{1'b1, 3'd5, 32'h0000_0030, 32'h0, 4'd7},
        '{1'b0, 3'd6, 32'h0, 32'hFFFF_FF3F, 4'd7}    // R7 mask set
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_i = '0;
    logic [7:0]  wr_stb_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    reg_bank u_reg_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_i     (evt_i),
        .wr_stb_o  (wr_stb_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic pulse_evt(input logic [31:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R10 irq at reset", {31'b0, irq_o}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                do_write(VEC[i].addr, VEC[i].data);
            end else begin
                do_read(VEC[i].addr, v);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
            end
        end

        // Mask now 0xFFFFFF3F: only bits 7:6 unmasked.
        pulse_evt(32'h0000_00FF);
        do_read(3'd3, v);
        check("R5 masked events dropped", v, 32'h0000_00C0);
        check("R9 irq raised", {31'b0, irq_o}, 32'h1);

        do_write(3'd3, 32'h0000_0040);
        do_read(3'd3, v);
        check("R6 clear on one", v, 32'h0000_0080);

        do_write(3'd5, 32'h0000_0080);
        check("R9 irq dropped when masked", {31'b0, irq_o}, 32'h0);
        do_read(3'd3, v);
        check("R9 status kept under mask", v, 32'h0000_0080);

        do_write(3'd4, 32'h0000_0080);
        check("R9 irq back on unmask", {31'b0, irq_o}, 32'h1);

        do_write(3'd3, 32'h0000_0080);
        check("R6 irq after full clear", {31'b0, irq_o}, 32'h0);

        // Event and clearing write on the same bit in one clock.
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0000_0040; evt_i = 32'h0000_0040;
        #1;
        check("R11 strobe on write", {24'b0, wr_stb_o}, 32'h0000_0008);
        @(negedge clk);
        bus_we = 1'b0; evt_i = '0;
        #1;
        check("R11 strobe idle", {24'b0, wr_stb_o}, 32'h0);
        do_read(3'd3, v);
        check("R5 event wins collision", v, 32'h0000_0040);

        // Read returns value from before a write in the same clock.
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 32'hCAFE_0001;
        @(negedge clk);
        bus_we = 1'b0;
        check("R4 read shows old value", bus_rdata, 32'h1234_5678);

        // Reset mid-run.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 irq after reset", {31'b0, irq_o}, 32'h0);
        do_read(3'd6, v);
        check("R10 mask after reset", v, 32'hFFFF_FFFF);
        do_read(3'd1, v);
        check("R10 cfg after reset", v, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule